// File: doc/BRIEF.md
# Cross-Domain Doorbell and Mailbox

This block sits between two independent host domains, called side A and side B, and lets each one raise events in the other and hand over short data words. Each side has its own register port with a write strobe, a read strobe, a word address and a data bus. Both ports run on one shared clock. A write on one port changes state seen by the other port: doorbell bits land in the peer's inbound register, and message words land in the peer's receive slots.

Each side owns three kinds of register. The first is an inbound doorbell, with one bit per event. The second is an interrupt-enable word for that doorbell. The third is a bank of message slots, each with a full flag. Each side drives two interrupt lines. The doorbell line is high while an enabled inbound bit is pending. The message line is high while any of its slots holds an unread word. The two sides are mirror images of each other.

Word addresses on each port are as follows:
- 0: outbound doorbell
- 1: inbound doorbell
- 2: doorbell enable
- 3: message flags
- 4 and up: message slots 0 to NMSG-1

Read data is registered. It appears in the cycle after the read strobe and holds until the next read.

Top module: `xdm_mailbox`

## Requirements
- R1: Writing word address 0 on one side ORs the written value into the peer's inbound doorbell, with no change on the writer's own side. Reading address 0 returns zero.
- R2: Address 1 returns the inbound doorbell. Each 1 written to address 1 clears the matching bit, and each 0 leaves its bit unchanged.
- R3: Address 2 is a read/write enable word. The doorbell interrupt is high exactly while some inbound bit is set whose enable bit is also set. A pending bit that is not enabled still reads back at address 1.
- R4: Writing message slot i (address 4+i) on one side stores the word in the peer's slot i and sets the peer's full flag i. Full flag i is bit i of address 3, and the upper bits of address 3 read as zero. The writer's own slot i is not changed.
- R5: Reading slot i clears the reader's full flag i, and the read returns the stored word. Writing a 1 to bit i of address 3 also clears flag i, while a 0 bit has no effect. The stored word survives either kind of clear.
- R6: The message interrupt is high exactly while any full flag on that side is set.
- R7: If a set and a clear hit the same bit in one cycle, the set wins. This covers a peer doorbell write against a local write-1-to-clear, and a peer message write against a local read or acknowledge. A read that races a new message returns the older word.
- R8: Both directions behave identically and may act in the same cycle without interfering.
- R9: After reset, all doorbell, enable, flag and slot state is zero and all four interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | ADDR_W | Side A word address |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A read data, one cycle after a_rd |
| a_db_irq | output | 1 | Side A doorbell interrupt |
| a_msg_irq | output | 1 | Side A message interrupt |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | ADDR_W | Side B word address |
| b_wdata | input | DATA_W | Side B write data |
| b_rdata | output | DATA_W | Side B read data, one cycle after b_rd |
| b_db_irq | output | 1 | Side B doorbell interrupt |
| b_msg_irq | output | 1 | Side B message interrupt |

## Verification
The bench builds the block with its default parameters: DATA_W of 32 and NMSG of 4. That gives a three-bit address whose eight codes are all decoded. With these values the stimulus can reach the top doorbell bit 31, the last message slot at address 7, and the flag word's bit 3. Same-cycle races are driven on both ports at once, covering doorbell set against clear, message arrival against read, and crossed outbound writes.

// File: rtl/xdm_pkg.sv
package xdm_pkg;
  localparam int SIDES   = 2;
  localparam int ADR_OUT = 0;
  localparam int ADR_IN  = 1;
  localparam int ADR_EN  = 2;
  localparam int ADR_FLG = 3;
  localparam int ADR_MSG = 4;

  function automatic int addr_width(input int nmsg);
    return $clog2(ADR_MSG + nmsg);
  endfunction

  function automatic int peer_of(input int side);
    return (side == 0) ? 1 : 0;
  endfunction
endpackage

// File: rtl/xdm_side_decode.sv
module xdm_side_decode
  import xdm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NMSG   = 4,
  parameter int ADDR_W = 3
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] out_set,
  output logic [DATA_W-1:0] in_clr,
  output logic              en_we,
  output logic [NMSG-1:0]   flg_ack,
  output logic [NMSG-1:0]   msg_we,
  output logic [NMSG-1:0]   msg_re
);
  logic [DATA_W-1:0] wdata_flg;

  assign wdata_flg = wdata;

  always_comb begin
    out_set = (wr && int'(addr) == ADR_OUT) ? wdata : '0;
    in_clr  = (wr && int'(addr) == ADR_IN)  ? wdata : '0;
    en_we   = wr && int'(addr) == ADR_EN;
    flg_ack = (wr && int'(addr) == ADR_FLG) ? wdata_flg[NMSG-1:0] : '0;
    for (int i = 0; i < NMSG; i++) begin
      msg_we[i] = wr && int'(addr) == ADR_MSG + i;
      msg_re[i] = rd && int'(addr) == ADR_MSG + i;
    end
  end
endmodule

// File: rtl/xdm_doorbell.sv
module xdm_doorbell #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] in_db,
  output logic [W-1:0] en,
  output logic         irq
);
  function automatic logic [W-1:0] db_next(input logic [W-1:0] cur,
                                           input logic [W-1:0] clr,
                                           input logic [W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic pending(input logic [W-1:0] bits,
                                   input logic [W-1:0] mask);
    return |(bits & mask);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_db <= '0;
      en    <= '0;
    end else begin
      in_db <= db_next(in_db, clr_v, set_v);
      if (en_we) en <= en_wdata;
    end
  end

  assign irq = pending(in_db, en);

  // R7
  db_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((in_db & $past(set_v)) == $past(set_v)));

  // R2
  db_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_v & ~set_v)) |=> ((in_db & $past(clr_v & ~set_v)) == '0));

  // R3
  db_irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_db == '0) |-> !irq);
endmodule

// File: rtl/xdm_msg_slot.sv
module xdm_msg_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         peer_we,
  input  logic [W-1:0] peer_wdata,
  input  logic         own_re,
  input  logic         own_ack,
  output logic [W-1:0] data,
  output logic         full
);
  function automatic logic full_next(input logic cur, input logic arrive,
                                     input logic drain);
    return arrive | (cur & ~drain);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
    end else begin
      if (peer_we) data <= peer_wdata;
      full <= full_next(full, peer_we, own_re | own_ack);
    end
  end

  // R4
  msg_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peer_we |=> (full && data == $past(peer_wdata)));

  // R5
  msg_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_re || own_ack) && !peer_we) |=> (!full && $stable(data)));
endmodule

// File: rtl/xdm_mailbox.sv
module xdm_mailbox
  import xdm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NMSG   = 4,
  parameter int ADDR_W = addr_width(NMSG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_db_irq,
  output logic              a_msg_irq,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_db_irq,
  output logic              b_msg_irq
);
  logic              wr_s    [SIDES];
  logic              rd_s    [SIDES];
  logic [ADDR_W-1:0] addr_s  [SIDES];
  logic [DATA_W-1:0] wdata_s [SIDES];
  logic [DATA_W-1:0] rdata_q [SIDES];
  logic              db_irq  [SIDES];
  logic              msg_irq [SIDES];

  logic [DATA_W-1:0] out_set [SIDES];
  logic [DATA_W-1:0] in_clr  [SIDES];
  logic              en_we   [SIDES];
  logic [NMSG-1:0]   flg_ack [SIDES];
  logic [NMSG-1:0]   msg_we  [SIDES];
  logic [NMSG-1:0]   msg_re  [SIDES];
  logic [DATA_W-1:0] in_db   [SIDES];
  logic [DATA_W-1:0] en_v    [SIDES];
  logic [NMSG-1:0]   full_v  [SIDES];
  logic [DATA_W-1:0] msg_data[SIDES][NMSG];

  assign wr_s[0] = a_wr;    assign wr_s[1] = b_wr;
  assign rd_s[0] = a_rd;    assign rd_s[1] = b_rd;
  assign addr_s[0] = a_addr;  assign addr_s[1] = b_addr;
  assign wdata_s[0] = a_wdata; assign wdata_s[1] = b_wdata;
  assign a_rdata   = rdata_q[0]; assign b_rdata   = rdata_q[1];
  assign a_db_irq  = db_irq[0];  assign b_db_irq  = db_irq[1];
  assign a_msg_irq = msg_irq[0]; assign b_msg_irq = msg_irq[1];

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int P = peer_of(s);
    logic [DATA_W-1:0] rd_mux;

    xdm_side_decode #(.DATA_W(DATA_W), .NMSG(NMSG), .ADDR_W(ADDR_W)) u_dec (
      .wr(wr_s[s]), .rd(rd_s[s]), .addr(addr_s[s]), .wdata(wdata_s[s]),
      .out_set(out_set[s]), .in_clr(in_clr[s]), .en_we(en_we[s]),
      .flg_ack(flg_ack[s]), .msg_we(msg_we[s]), .msg_re(msg_re[s])
    );

    xdm_doorbell #(.W(DATA_W)) u_db (
      .clk(clk), .rst_n(rst_n),
      .set_v(out_set[P]), .clr_v(in_clr[s]),
      .en_we(en_we[s]), .en_wdata(wdata_s[s]),
      .in_db(in_db[s]), .en(en_v[s]), .irq(db_irq[s])
    );

    for (genvar i = 0; i < NMSG; i++) begin : g_slot
      xdm_msg_slot #(.W(DATA_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .peer_we(msg_we[P][i]), .peer_wdata(wdata_s[P]),
        .own_re(msg_re[s][i]), .own_ack(flg_ack[s][i]),
        .data(msg_data[s][i]), .full(full_v[s][i])
      );
    end

    assign msg_irq[s] = |full_v[s];

    always_comb begin
      rd_mux = '0;
      if (int'(addr_s[s]) == ADR_IN)       rd_mux = in_db[s];
      else if (int'(addr_s[s]) == ADR_EN)  rd_mux = en_v[s];
      else if (int'(addr_s[s]) == ADR_FLG) rd_mux = DATA_W'(full_v[s]);
      else begin
        for (int i = 0; i < NMSG; i++)
          if (int'(addr_s[s]) == ADR_MSG + i) rd_mux = msg_data[s][i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdata_q[s] <= '0;
      else if (rd_s[s])   rdata_q[s] <= rd_mux;
    end

    // R1
    out_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_s[s] && int'(addr_s[s]) == ADR_OUT) |=> (rdata_q[s] == '0));

    // R6
    msg_irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_we[P] != '0) |=> msg_irq[s]);

    // R8
    peer_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_set[P] & en_v[s]) != '0) |=> db_irq[s]);
  end
endmodule

// File: tb/xdm_mailbox_tb_top.sv
module xdm_mailbox_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [2:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic a_db_irq, a_msg_irq, b_db_irq, b_msg_irq;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  xdm_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_db_irq(a_db_irq), .a_msg_irq(a_msg_irq),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_db_irq(b_db_irq), .b_msg_irq(b_msg_irq)
  );

  typedef struct packed {
    logic        side;  // 0 = A, 1 = B
    logic        rd;
    logic [2:0]  addr;
    logic [31:0] data;  // write data, or expected read data
    logic [3:0]  irq;   // {a_db, a_msg, b_db, b_msg}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 3'd2, 32'h0000_00FF, 4'b0000, 4'd3}, // R3 enable B
    '{1'b0, 1'b0, 3'd0, 32'h0000_0005, 4'b0010, 4'd1}, // R1 ring B
    '{1'b0, 1'b1, 3'd0, 32'h0000_0000, 4'b0010, 4'd1}, // R1 outbound reads 0
    '{1'b1, 1'b1, 3'd1, 32'h0000_0005, 4'b0010, 4'd1}, // R1
    '{1'b1, 1'b0, 3'd1, 32'h0000_0004, 4'b0010, 4'd2}, // R2 partial clear
    '{1'b1, 1'b1, 3'd1, 32'h0000_0001, 4'b0010, 4'd2}, // R2
    '{1'b1, 1'b0, 3'd1, 32'h0000_0001, 4'b0000, 4'd2}, // R2
    '{1'b0, 1'b0, 3'd0, 32'h0000_0100, 4'b0000, 4'd3}, // R3 disabled bit
    '{1'b1, 1'b1, 3'd1, 32'h0000_0100, 4'b0000, 4'd3}, // R3
    '{1'b1, 1'b0, 3'd2, 32'h0000_01FF, 4'b0010, 4'd3}, // R3 enable it
    '{1'b1, 1'b1, 3'd2, 32'h0000_01FF, 4'b0010, 4'd3}, // R3 readback
    '{1'b1, 1'b0, 3'd1, 32'h0000_0100, 4'b0000, 4'd2}, // R2
    '{1'b0, 1'b0, 3'd2, 32'hFFFF_FFFF, 4'b0000, 4'd8}, // R8 enable A
    '{1'b1, 1'b0, 3'd0, 32'h8000_0000, 4'b1000, 4'd8}, // R8 ring A
    '{1'b0, 1'b1, 3'd1, 32'h8000_0000, 4'b1000, 4'd8}, // R8
    '{1'b0, 1'b0, 3'd1, 32'h8000_0000, 4'b0000, 4'd2}, // R2
    '{1'b0, 1'b0, 3'd4, 32'hCAFE_0001, 4'b0001, 4'd4}, // R4 A to B slot0
    '{1'b1, 1'b1, 3'd3, 32'h0000_0001, 4'b0001, 4'd4}, // R4 flag bit0
    '{1'b1, 1'b1, 3'd4, 32'hCAFE_0001, 4'b0000, 4'd5}, // R5 read drains
    '{1'b1, 1'b1, 3'd3, 32'h0000_0000, 4'b0000, 4'd5}, // R5
    '{1'b1, 1'b0, 3'd7, 32'h1234_5678, 4'b0100, 4'd8}, // R8 B to A slot3
    '{1'b0, 1'b1, 3'd3, 32'h0000_0008, 4'b0100, 4'd4}, // R4 flag bit3
    '{1'b0, 1'b0, 3'd3, 32'h0000_0007, 4'b0100, 4'd5}, // R5 zero bit kept
    '{1'b0, 1'b0, 3'd3, 32'h0000_0008, 4'b0000, 4'd5}, // R5 acknowledge
    '{1'b0, 1'b1, 3'd7, 32'h1234_5678, 4'b0000, 4'd5}, // R5 data kept
    '{1'b0, 1'b1, 3'd4, 32'h0000_0000, 4'b0000, 4'd4}, // R4 writer slot untouched
    '{1'b0, 1'b0, 3'd5, 32'h0BAD_F00D, 4'b0001, 4'd6}, // R6
    '{1'b0, 1'b0, 3'd6, 32'h600D_BEEF, 4'b0001, 4'd6}, // R6
    '{1'b1, 1'b1, 3'd5, 32'h0BAD_F00D, 4'b0001, 4'd6}, // R6 one still full
    '{1'b1, 1'b1, 3'd6, 32'h600D_BEEF, 4'b0000, 4'd6}  // R6 none full
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_port(input bit side, input bit rd, input logic [2:0] addr,
                          input logic [31:0] data);
    if (side == 1'b0) begin
      a_wr = !rd; a_rd = rd; a_addr = addr; a_wdata = data;
    end else begin
      b_wr = !rd; b_rd = rd; b_addr = addr; b_wdata = data;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
  endtask

  task automatic op(input bit side, input bit rd, input logic [2:0] addr,
                    input logic [31:0] data);
    set_port(side, rd, addr, data);
    tick();
  endtask

  function automatic logic [3:0] irqs();
    return {a_db_irq, a_msg_irq, b_db_irq, b_msg_irq};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(9, "irqs after reset", 32'(irqs()), 32'h0);
    op(1'b1, 1'b1, 3'd1, '0);
    check(9, "B inbound after reset", b_rdata, 32'h0);
    op(1'b0, 1'b1, 3'd3, '0);
    check(9, "A flags after reset", a_rdata, 32'h0);

    for (int v = 0; v < NV; v++) begin
      op(VECS[v].side, VECS[v].rd, VECS[v].addr, VECS[v].data);
      if (VECS[v].rd)
        check(int'(VECS[v].req), $sformatf("vector %0d read", v),
              VECS[v].side ? b_rdata : a_rdata, VECS[v].data);
      check(int'(VECS[v].req), $sformatf("vector %0d irqs", v),
            32'(irqs()), 32'(VECS[v].irq));
    end

    // R7 doorbell: set and clear of bit 3 in one cycle, set wins
    op(1'b0, 1'b0, 3'd0, 32'h8);
    set_port(1'b0, 1'b0, 3'd0, 32'h8);
    set_port(1'b1, 1'b0, 3'd1, 32'h8);
    tick();
    check(7, "B db irq after race", 32'(b_db_irq), 32'h1);
    op(1'b1, 1'b1, 3'd1, '0);
    check(7, "B inbound after race", b_rdata, 32'h8);
    op(1'b1, 1'b0, 3'd1, 32'h8);
    check(2, "B db irq after clear", 32'(b_db_irq), 32'h0);

    // R7 message: arrival races a read of the same slot
    op(1'b0, 1'b0, 3'd4, 32'h1111_1111);
    set_port(1'b0, 1'b0, 3'd4, 32'h2222_2222);
    set_port(1'b1, 1'b1, 3'd4, '0);
    tick();
    check(7, "B read during arrival", b_rdata, 32'h1111_1111);
    check(7, "B msg irq kept", 32'(b_msg_irq), 32'h1);
    op(1'b1, 1'b1, 3'd3, '0);
    check(7, "B flags after race", b_rdata, 32'h1);
    op(1'b1, 1'b1, 3'd4, '0);
    check(7, "B new word", b_rdata, 32'h2222_2222);
    check(6, "B msg irq drained", 32'(b_msg_irq), 32'h0);

    // R8 crossed outbound writes in one cycle
    set_port(1'b0, 1'b0, 3'd0, 32'h2);
    set_port(1'b1, 1'b0, 3'd0, 32'h4);
    tick();
    set_port(1'b0, 1'b1, 3'd1, '0);
    set_port(1'b1, 1'b1, 3'd1, '0);
    tick();
    check(8, "A inbound crossed", a_rdata, 32'h4);
    check(8, "B inbound crossed", b_rdata, 32'h2);
    check(8, "both db irqs", 32'({a_db_irq, b_db_irq}), 32'h3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule